// File: doc/BRIEF.md
# Reference Clock Loss Monitor

This block watches up to four reference clocks and decides, for each one, whether it is running at roughly the expected rate. Each reference and a local oscillator clock pass through their own programmable divide-by-N prescaler. The divisors are chosen so that every divided clock arrives at one shared comparison rate. The divided oscillator provides the timebase. A reference is marked lost when three divided-oscillator ticks fall strictly inside one divided-reference period. In practice this means the reference has stopped or has slowed by about a factor of two. Counting three ticks instead of two keeps clocks that are almost matched, and slide past each other in phase, from raising false alarms.

The same comparison also runs the other way. When three divided ticks of a reference that is currently trusted arrive inside one divided-oscillator period, the oscillator is the clock running slow. The block then raises a single warning. It takes no further action: no loss flag is changed.

A reference that comes back must run one full period short enough to pass the test. It then waits out a programmable validation interval of two to three periods of a shared validation timer before its loss flag clears. Fast clocks are oversampled by a system clock, so a glitching input can never stall a divider or the detector. If a divisor is reduced in the middle of a count, the prescaler recovers on the next input edge.

Top module: `ref_loss_monitor`

## Requirements
- R1: While reset is held and right after it is released, every loss flag reads 1 and the warning reads 0.
- R2: A prescaler setting of s divides by s+1, counting rising edges of its raw input. Each reference and the oscillator has its own setting. Reference i uses bits [8i+7:8i] of `ref_div_i`.
- R3: A reference's loss flag sets once three divided-oscillator ticks occur strictly inside one divided-reference period. This covers a stopped reference and a reference with at least three oscillator periods between its ticks.
- R4: A reference whose divided period is twice the divided oscillator period, or shorter, never has its loss flag set.
- R5: The warning rises when a reference whose flag is clear produces three divided ticks strictly inside one divided-oscillator period. It stays high while every oscillator period keeps that count. Loss flags are not affected by it.
- R6: A reference whose loss flag is set never causes the warning, even if that reference ticks fast.
- R7: `valid_code_i` values 1 to 7 select validation periods of 1, 2, 4, 8, 16, 32 and 64 divided-oscillator ticks. A lost reference qualifies once it runs one divided period with fewer than three oscillator ticks inside it. Its flag then clears at the third timer expiry that follows, which is 2 to 3 validation periods later.
- R8: With `valid_code_i` = 0 there is no hysteresis: a lost reference's flag clears at its first qualifying period.
- R9: If the loss condition recurs while a reference waits for validation, the expiries counted so far are discarded. The next recovery has to wait the full interval again.
- R10: If a prescaler setting is lowered below the prescaler's current count, the next raw rising edge produces a divided tick. The divider does not wrap around its full range first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_in | input | NUM_REFS | Raw reference clocks, asynchronous |
| osc_clk_in | input | 1 | Raw local oscillator clock, asynchronous |
| ref_div_i | input | NUM_REFS*DIV_W | Per-reference prescaler settings (ratio = setting+1) |
| osc_div_i | input | DIV_W | Oscillator prescaler setting (ratio = setting+1) |
| valid_code_i | input | CODE_W | Validation period select, 0 = no hysteresis |
| los_o | output | NUM_REFS | Per-reference loss flag, 1 = lost or not yet validated |
| osc_slow_o | output | 1 | Warning: oscillator slow against a trusted reference |

## Verification
Some rules are checked by assertions on every cycle. A loss flag may rise only on a divided-oscillator tick. It may fall only on a timer expiry, or on a reference tick when hysteresis is off. The warning may rise only on a reference tick, and it needs at least one trusted reference. Consecutive validation expiries must lie exactly one programmed period apart. Other behaviour depends on real frequency relationships between the inputs, and only the bench scenarios can show it. These are the octave threshold, the absence of false flags at half rate, the 2-to-3-period recovery window for several codes, the restart of validation after a relapse, and the divider recovery after reprogramming.

// File: rtl/ref_loss_pkg.sv
package ref_loss_pkg;

  typedef enum logic [1:0] {
    ST_LOST  = 2'd0,
    ST_ARMED = 2'd1,
    ST_GOOD  = 2'd2
  } ref_state_e;

  // Validation period in divided-oscillator ticks for a 3-bit select.
  function automatic int valid_period(input logic [2:0] code);
    if (code == 3'd0) return 0;
    return 1 << (int'(code) - 1);
  endfunction

endpackage

// File: rtl/rlm_prescaler.sv
module rlm_prescaler #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic [DIV_W-1:0]     cnt_q;
  logic                 rise;
  logic                 wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], raw_i};
  end

  assign rise   = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  // ">=" rather than "==" so a lowered setting never forces a full wrap.
  assign wrap   = (cnt_q >= div_i);
  assign tick_o = rise & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (rise) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R2: a divided output never ticks in two consecutive cycles when dividing.
  assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i != '0 && tick_o) |=> !tick_o);

endmodule

// File: rtl/rlm_valid_timer.sv
module rlm_valid_timer #(
  parameter int CODE_W = 3,
  parameter int PER_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              expire_o
);
  logic [PER_W-1:0] per;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W:0]   nxt;

  assign per      = PER_W'(ref_loss_pkg::valid_period(3'(code_i)));
  assign nxt      = {1'b0, cnt_q} + (PER_W+1)'(1);
  assign expire_o = osc_tick_i && (per != '0) && (nxt >= {1'b0, per});

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (expire_o)   cnt_q <= '0;
    else if (osc_tick_i) cnt_q <= nxt[PER_W-1:0];
  end

  // Independent spacing counter for the assertion below.
  logic [PER_W:0]    gap_q;
  logic              gap_ok_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0; gap_ok_q <= 1'b0; code_q <= '0;
    end else begin
      code_q <= code_i;
      if (expire_o)        gap_q <= '0;
      else if (osc_tick_i) gap_q <= gap_q + 1'b1;
      if (code_i != code_q) gap_ok_q <= 1'b0;
      else if (expire_o)    gap_ok_q <= 1'b1;
    end
  end

  // R7: with a steady select, expiries lie exactly one period of ticks apart.
  assert_expiry_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && gap_ok_q && code_i == code_q) |-> (gap_q + 1'b1 == {1'b0, per}));

endmodule

// File: rtl/rlm_ref_checker.sv
module rlm_ref_checker #(
  parameter int LOSS_EDGES    = 3,
  parameter int EXPIRY_NEEDED = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick_i,
  input  logic osc_tick_i,
  input  logic expire_i,
  input  logic no_hyst_i,
  output logic lost_o,
  output logic osc_slow_o
);
  import ref_loss_pkg::*;

  localparam int CNT_W = $clog2(LOSS_EDGES + 1);
  localparam int EXP_W = $clog2(EXPIRY_NEEDED + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOSS_EDGES);

  logic [CNT_W-1:0] osc_cnt_q, ref_cnt_q;
  logic [EXP_W-1:0] exp_cnt_q;
  ref_state_e       state_q;
  logic             warn_q;

  // Named internal events.
  logic loss_hit;     // third oscillator tick inside one reference period
  logic fast_period;  // reference period with fewer than three oscillator ticks
  logic warn_hit;     // third reference tick inside one oscillator period
  logic last_expiry;

  assign loss_hit    = osc_tick_i && !ref_tick_i && (osc_cnt_q == CNT_MAX - 1'b1);
  assign fast_period = ref_tick_i && (osc_cnt_q < CNT_MAX);
  assign warn_hit    = ref_tick_i && !osc_tick_i && (ref_cnt_q == CNT_MAX - 1'b1);
  assign last_expiry = expire_i && (exp_cnt_q == EXP_W'(EXPIRY_NEEDED - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_cnt_q <= CNT_MAX;
      ref_cnt_q <= '0;
    end else begin
      if (ref_tick_i)                         osc_cnt_q <= '0;
      else if (osc_tick_i && osc_cnt_q != CNT_MAX) osc_cnt_q <= osc_cnt_q + 1'b1;
      if (osc_tick_i)                         ref_cnt_q <= '0;
      else if (ref_tick_i && ref_cnt_q != CNT_MAX) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_LOST;
      exp_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_GOOD: if (loss_hit) state_q <= ST_LOST;
        ST_LOST: begin
          exp_cnt_q <= '0;
          if (fast_period) state_q <= no_hyst_i ? ST_GOOD : ST_ARMED;
        end
        ST_ARMED: begin
          if (loss_hit) begin
            state_q   <= ST_LOST;
            exp_cnt_q <= '0;
          end else if (no_hyst_i) begin
            if (fast_period) state_q <= ST_GOOD;
          end else if (last_expiry) begin
            state_q   <= ST_GOOD;
            exp_cnt_q <= '0;
          end else if (expire_i) begin
            exp_cnt_q <= exp_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_LOST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                warn_q <= 1'b0;
    else if (state_q != ST_GOOD) warn_q <= 1'b0;
    else if (warn_hit)         warn_q <= 1'b1;
    else if (osc_tick_i)       warn_q <= (ref_cnt_q == CNT_MAX);
  end

  assign lost_o     = (state_q != ST_GOOD);
  assign osc_slow_o = warn_q && (state_q == ST_GOOD);

  // R3: a loss flag can only be raised by an oscillator tick.
  assert_loss_on_osc_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_o) |-> $past(osc_tick_i));

  // R7 / R8: a loss flag clears only on a timer expiry or, without hysteresis, a reference tick.
  assert_clear_needs_evidence_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost_o) |-> ($past(expire_i) || $past(ref_tick_i && no_hyst_i)));

  // R5: the warning can only rise on a reference tick.
  assert_warn_on_ref_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_slow_o) |-> $past(ref_tick_i));

  // R9: a relapse during validation returns the flag to lost with no expiries kept.
  assert_relapse_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && osc_tick_i && !ref_tick_i && osc_cnt_q == CNT_MAX - 1'b1)
      |=> (lost_o && exp_cnt_q == '0));

endmodule

// File: rtl/ref_loss_monitor.sv
module ref_loss_monitor #(
  parameter int NUM_REFS      = 4,
  parameter int DIV_W         = 8,
  parameter int CODE_W        = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int LOSS_EDGES    = 3,
  parameter int EXPIRY_NEEDED = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REFS-1:0]       ref_clk_in,
  input  logic                      osc_clk_in,
  input  logic [NUM_REFS*DIV_W-1:0] ref_div_i,
  input  logic [DIV_W-1:0]          osc_div_i,
  input  logic [CODE_W-1:0]         valid_code_i,
  output logic [NUM_REFS-1:0]       los_o,
  output logic                      osc_slow_o
);
  localparam int PER_W = (1 << CODE_W) - 1;

  logic                osc_tick;
  logic                expire;
  logic                no_hyst;
  logic [NUM_REFS-1:0] ref_tick;
  logic [NUM_REFS-1:0] slow_vote;

  assign no_hyst = (valid_code_i == '0);

  rlm_prescaler #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_osc_div (
    .clk(clk), .rst_n(rst_n), .raw_i(osc_clk_in), .div_i(osc_div_i), .tick_o(osc_tick));

  rlm_valid_timer #(.CODE_W(CODE_W), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick), .code_i(valid_code_i),
    .expire_o(expire));

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
    rlm_prescaler #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_div (
      .clk(clk), .rst_n(rst_n), .raw_i(ref_clk_in[g]),
      .div_i(ref_div_i[g*DIV_W +: DIV_W]), .tick_o(ref_tick[g]));

    rlm_ref_checker #(.LOSS_EDGES(LOSS_EDGES), .EXPIRY_NEEDED(EXPIRY_NEEDED)) u_chk (
      .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick[g]), .osc_tick_i(osc_tick),
      .expire_i(expire), .no_hyst_i(no_hyst), .lost_o(los_o[g]),
      .osc_slow_o(slow_vote[g]));
  end

  assign osc_slow_o = |slow_vote;

  // R6: the warning requires at least one reference that is not flagged lost.
  assert_warn_live_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
    osc_slow_o |-> !(&los_o));

  // R1: flags are all set in the first cycle after reset.
  assert_reset_flags_R1: assert property (@(posedge clk)
    !rst_n |=> (&los_o && !osc_slow_o));

endmodule

// File: tb/ref_loss_monitor_tb.sv
module ref_loss_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ref_clk_in = '0;
  logic        osc_clk_in = 1'b0;
  logic [31:0] ref_div_i = '0;
  logic [7:0]  osc_div_i = '0;
  logic [2:0]  valid_code_i = '0;
  logic [3:0]  los_o;
  logic        osc_slow_o;

  int osc_half = 4;
  int ref_half [4] = '{4, 4, 4, 4};
  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ref_loss_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .osc_clk_in(osc_clk_in),
    .ref_div_i(ref_div_i), .osc_div_i(osc_div_i), .valid_code_i(valid_code_i),
    .los_o(los_o), .osc_slow_o(osc_slow_o));

  // Square-wave generators; half period in system cycles, 0 holds the level.
  initial begin
    int oph;
    int rph [4];
    oph = 0;
    for (int i = 0; i < 4; i++) rph[i] = 0;
    forever begin
      @(negedge clk);
      if (osc_half != 0) begin
        oph++;
        if (oph >= osc_half) begin oph = 0; osc_clk_in = ~osc_clk_in; end
      end
      for (int i = 0; i < 4; i++) begin
        if (ref_half[i] != 0) begin
          rph[i]++;
          if (rph[i] >= ref_half[i]) begin rph[i] = 0; ref_clk_in[i] = ~ref_clk_in[i]; end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycles until los_o[idx] falls, capped at limit.
  task automatic time_clear(input int idx, input int limit, output int n);
    n = 0;
    while (los_o[idx] && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    wait_cyc(5);
    check(los_o == 4'hF, "R1 flags in reset", los_o, 15);
    check(osc_slow_o == 1'b0, "R1 warning in reset", osc_slow_o, 0);
    rst_n = 1'b1;
    wait_cyc(1);
    check(los_o == 4'hF, "R1 flags after release", los_o, 15);
  endtask

  task automatic t_no_hysteresis;
    valid_code_i = 3'd0;
    wait_cyc(60);
    check(los_o == 4'h0, "R8 all refs validated at once", los_o, 0);
    check(osc_slow_o == 1'b0, "R8 no warning when matched", osc_slow_o, 0);
  endtask

  task automatic t_stop;
    ref_half[2] = 0;
    wait_cyc(50);
    check(los_o == 4'b0100, "R3 stopped ref flagged", los_o, 4);
    ref_half[2] = 4;
    wait_cyc(50);
    check(los_o == 4'h0, "R8 stopped ref recovers", los_o, 0);
  endtask

  task automatic t_octave;
    int hits;
    ref_half[3] = 14;   // 3.5 oscillator periods per reference period
    wait_cyc(200);
    check(los_o[3] == 1'b1, "R3 slow ref flagged", los_o[3], 1);
    ref_half[3] = 4;
    wait_cyc(60);
    ref_half[1] = 8;    // exactly two oscillator periods
    hits = 0;
    for (int k = 0; k < 60; k++) begin
      wait_cyc(10);
      if (los_o[1]) hits++;
    end
    check(hits == 0, "R4 half-rate ref never flagged", hits, 0);
    ref_half[1] = 4;
    wait_cyc(60);
    check(los_o == 4'h0, "R3 all good again", los_o, 0);
  endtask

  task automatic t_prescale;
    osc_div_i = 8'd1; osc_half = 2;             // divided oscillator: 8 cycles
    ref_div_i[7:0] = 8'd4; ref_half[0] = 3;     // divided ref0: 30 cycles
    wait_cyc(200);
    check(los_o == 4'b0001, "R2 ref0 divided by five is lost", los_o, 1);
    ref_div_i[7:0] = 8'd1;                      // divided ref0: 12 cycles
    wait_cyc(200);
    check(los_o == 4'h0, "R2 ref0 divided by two is good", los_o, 0);
    ref_div_i[7:0] = 8'd0; ref_half[0] = 4;
    osc_div_i = 8'd0; osc_half = 4;
    wait_cyc(100);
    check(los_o == 4'h0, "R2 restored settings good", los_o, 0);
  endtask

  task automatic t_warn;
    osc_half = 14;
    wait_cyc(150);
    check(osc_slow_o == 1'b1, "R5 slow oscillator warned", osc_slow_o, 1);
    check(los_o == 4'h0, "R5 warning takes no action", los_o, 0);
    wait_cyc(97);
    check(osc_slow_o == 1'b1, "R5 warning held", osc_slow_o, 1);
    osc_half = 4;
    wait_cyc(100);
    check(osc_slow_o == 1'b0, "R5 warning drops", osc_slow_o, 0);
  endtask

  task automatic t_warn_lost;
    valid_code_i = 3'd7;
    for (int i = 0; i < 4; i++) ref_half[i] = 0;
    wait_cyc(60);
    check(los_o == 4'hF, "R6 all refs lost", los_o, 15);
    osc_half = 14;
    ref_half[0] = 4;
    wait_cyc(200);
    check(osc_slow_o == 1'b0, "R6 lost fast ref gives no warning", osc_slow_o, 0);
    check(los_o[0] == 1'b1, "R7 still validating", los_o[0], 1);
    wait_cyc(6000);
    check(los_o[0] == 1'b0, "R7 long validation completes", los_o[0], 0);
    check(osc_slow_o == 1'b1, "R5 warning once ref trusted", osc_slow_o, 1);
    osc_half = 4;
    valid_code_i = 3'd0;
    for (int i = 0; i < 4; i++) ref_half[i] = 4;
    wait_cyc(100);
    check(los_o == 4'h0 && !osc_slow_o, "R8 return to nominal", los_o, 0);
  endtask

  task automatic t_valid_timing(input logic [2:0] code, input int lo, input int hi);
    int n;
    valid_code_i = code;
    ref_half[1] = 0;
    wait_cyc(60);
    check(los_o[1] == 1'b1, "R3 ref1 lost before timing", los_o[1], 1);
    ref_half[1] = 4;
    time_clear(1, hi + 50, n);
    check(n >= lo && n <= hi, $sformatf("R7 clear time code %0d", code), n, lo);
  endtask

  task automatic t_relapse;
    int n;
    valid_code_i = 3'd3;               // 4 ticks = 32 cycles per period
    ref_half[2] = 0;
    wait_cyc(60);
    ref_half[2] = 4;
    wait_cyc(50);
    ref_half[2] = 0;
    wait_cyc(50);
    check(los_o[2] == 1'b1, "R9 relapse flagged", los_o[2], 1);
    ref_half[2] = 4;
    time_clear(2, 300, n);
    check(n >= 64 && n <= 128, "R9 full interval after relapse", n, 64);
  endtask

  task automatic t_reprogram;
    valid_code_i = 3'd0;
    ref_div_i[31:24] = 8'd200;
    wait_cyc(1200);
    check(los_o[3] == 1'b1, "R10 heavily divided ref lost", los_o[3], 1);
    ref_div_i[31:24] = 8'd0;
    wait_cyc(60);
    check(los_o[3] == 1'b0, "R10 lowered setting recovers quickly", los_o[3], 0);
  endtask

  initial begin
    wait_cyc(150000);
    fails++; total++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_no_hysteresis();
    t_stop();
    t_octave();
    t_prescale();
    t_warn();
    t_warn_lost();
    t_valid_timing(3'd1, 16, 60);
    t_valid_timing(3'd3, 64, 128);
    t_valid_timing(3'd7, 1024, 1600);
    t_relapse();
    t_reprogram();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule